// File: doc/BRIEF.md
# Flash Program and Erase Timing Sequencer

This block produces the fixed-length timing windows that a flash controller needs to program and erase its array. It counts cycles of a dedicated flash timing clock and, for each accepted command, holds a busy indication and either a program strobe or an erase strobe for that command's cycle count. Single word writes, the first and later items of a block write, the wait that closes a block write, segment erase and mass erase each have their own length.

The sequencer also guards the array. It refuses any command that arrives while an operation is running, any command that does not fit the current block-write state, and any command aimed at the protected segment while that segment is locked. Each refusal sets a sticky violation flag. For each target block it sums the cycles spent with the program strobe high, and it raises a sticky error once that sum passes a programmable ceiling. The default ceiling of 4760 cycles is 10 ms at the fastest timing clock. The surrounding controller supplies the command, the target block index, and a flag that marks the protected segment.

Top module: `flash_seq_top`

## Requirements
- R1: Reset state: busy, both strobes, block mode, violation and cumulative error are low, and the protected segment is locked (prot_locked high).
- R2: A word write (cmd_op 0) that is accepted holds busy and prog_pulse high for exactly 30 cycles, starting on the cycle after acceptance. Busy is low on the cycle after the last count.
- R3: An accepted block start (cmd_op 1) programs for 25 cycles and then leaves blk_open high. Each block next (cmd_op 2) programs for 18 cycles. One block holds at most 64 items, the first one included, so the 64th block next is refused.
- R4: A block end (cmd_op 3) holds busy for 6 cycles with no program strobe and clears blk_open.
- R5: A segment erase (cmd_op 4) holds busy and erase_pulse high for 4819 cycles.
- R6: A mass erase (cmd_op 5) holds busy and erase_pulse high for 10593 cycles. prog_pulse and erase_pulse are never high together.
- R7: A command issued while busy is refused and sets acc_viol. acc_viol stays high until reset, and the running operation keeps its full length.
- R8: A command that does not fit the block state is refused and sets acc_viol. This covers block next or block end outside a block write, word write, block start or erase inside a block write, and the reserved codes 6 and 7.
- R9: While prot_locked is high, a command with cmd_prot high is refused and sets acc_viol. A prot_unlock pulse clears prot_locked, and a prot_lock pulse sets it again. Lock wins if both are high.
- R10: The sequencer sums program-strobe cycles per target block. The sum restarts when a word write or block start names a different block, and after an erase. When the sum passes CUM_LIMIT, cum_err goes high and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Flash timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Operation code (0 word, 1 block start, 2 block next, 3 block end, 4 segment erase, 5 mass erase) |
| cmd_prot | input | 1 | Command targets the protected segment |
| cmd_blk | input | BLK_AW | Target block index for program-time accounting |
| prot_unlock | input | 1 | Pulse that unlocks the protected segment |
| prot_lock | input | 1 | Pulse that locks the protected segment |
| busy | output | 1 | Operation in progress |
| prog_pulse | output | 1 | Program strobe |
| erase_pulse | output | 1 | Erase strobe |
| blk_open | output | 1 | Block write in progress |
| prot_locked | output | 1 | Protected segment locked |
| acc_viol | output | 1 | Sticky command violation |
| cum_err | output | 1 | Sticky cumulative program-time error |

## Verification
The assertions check several properties on every cycle:
- A timer load happens only while the sequencer is idle.
- Busy falls on the cycle after the final count.
- The two strobes never overlap.
- A block end never raises the program strobe.
- The item count never exceeds its limit.
- The violation and cumulative flags stay set once raised.

Other behaviours can only be shown by the bench's scenarios:
- The exact length of each operation.
- Refusal of out-of-state and locked commands.
- The 64-item ceiling on a block.
- The per-block restart of the time sum, and the threshold at which it trips.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    OP_WORD   = 3'd0,
    OP_BSTART = 3'd1,
    OP_BNEXT  = 3'd2,
    OP_BEND   = 3'd3,
    OP_SERASE = 3'd4,
    OP_MERASE = 3'd5,
    OP_RSV6   = 3'd6,
    OP_RSV7   = 3'd7
  } fop_e;

  typedef enum logic [1:0] {
    PK_NONE  = 2'd0,
    PK_PROG  = 2'd1,
    PK_ERASE = 2'd2
  } pkind_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/flash_seq_gate.sv
module flash_seq_gate
  import flash_seq_pkg::*;
(
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic       cmd_prot,
  input  logic       busy,
  input  logic       blk_open,
  input  logic       items_full,
  input  logic       locked,
  output logic       accept,
  output logic       reject
);

  logic fits;

  always_comb begin
    case (fop_e'(cmd_op))
      OP_WORD, OP_BSTART, OP_SERASE, OP_MERASE: fits = !blk_open;
      OP_BNEXT:                                 fits = blk_open && !items_full;
      OP_BEND:                                  fits = blk_open;
      default:                                  fits = 1'b0;
    endcase
    accept = cmd_valid && !busy && fits && !(cmd_prot && locked);
    reject = cmd_valid && !accept;
  end

endmodule

// File: rtl/flash_seq_timer.sv
module flash_seq_timer
  import flash_seq_pkg::*;
#(
  parameter int unsigned CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  pkind_e        load_kind,
  output logic          busy,
  output logic          prog_pulse,
  output logic          erase_pulse
);

  logic [CW-1:0] remain_q, remain_d;
  pkind_e        kind_q, kind_d;

  always_comb begin
    remain_d = remain_q;
    kind_d   = kind_q;
    if (load) begin
      remain_d = load_val;
      kind_d   = load_kind;
    end else if (remain_q != '0) begin
      remain_d = remain_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
      kind_q   <= PK_NONE;
    end else begin
      remain_q <= remain_d;
      kind_q   <= kind_d;
    end
  end

  assign busy        = (remain_q != '0);
  assign prog_pulse  = busy && (kind_q == PK_PROG);
  assign erase_pulse = busy && (kind_q == PK_ERASE);

  p_load_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);
  p_busy_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (remain_q == CW'(1)) |=> !busy);
  p_pulse_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_pulse && erase_pulse));

endmodule

// File: rtl/flash_seq_cum.sv
module flash_seq_cum #(
  parameter int unsigned LIMIT  = 4760,
  parameter int unsigned BLK_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_start,
  input  logic              erase_start,
  input  logic [BLK_AW-1:0] blk,
  input  logic              prog_pulse,
  output logic              err
);

  localparam int unsigned CNW = $clog2(LIMIT + 2);
  localparam logic [CNW-1:0] SAT = CNW'(LIMIT + 1);

  logic [CNW-1:0]    cnt_q, cnt_d;
  logic [BLK_AW-1:0] blk_q, blk_d;
  logic              bval_q, bval_d;
  logic              err_q, err_d;

  always_comb begin
    cnt_d  = cnt_q;
    blk_d  = blk_q;
    bval_d = bval_q;
    if (erase_start) begin
      cnt_d  = '0;
      bval_d = 1'b0;
    end else if (prog_start && (!bval_q || blk != blk_q)) begin
      cnt_d  = '0;
      blk_d  = blk;
      bval_d = 1'b1;
    end else if (prog_pulse && cnt_q != SAT) begin
      cnt_d = cnt_q + 1'b1;
    end
    err_d = err_q || (cnt_q > CNW'(LIMIT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      blk_q  <= '0;
      bval_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      blk_q  <= blk_d;
      bval_q <= bval_d;
      err_q  <= err_d;
    end
  end

  assign err = err_q;

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

endmodule

// File: rtl/flash_seq_top.sv
module flash_seq_top
  import flash_seq_pkg::*;
#(
  parameter int unsigned T_WORD    = 30,
  parameter int unsigned T_BFIRST  = 25,
  parameter int unsigned T_BNEXT   = 18,
  parameter int unsigned T_BEND    = 6,
  parameter int unsigned T_SEG     = 4819,
  parameter int unsigned T_MASS    = 10593,
  parameter int unsigned BLK_ITEMS = 64,
  parameter int unsigned CUM_LIMIT = 4760,
  parameter int unsigned BLK_AW    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic              cmd_prot,
  input  logic [BLK_AW-1:0] cmd_blk,
  input  logic              prot_unlock,
  input  logic              prot_lock,
  output logic              busy,
  output logic              prog_pulse,
  output logic              erase_pulse,
  output logic              blk_open,
  output logic              prot_locked,
  output logic              acc_viol,
  output logic              cum_err
);

  localparam int unsigned TMAX = umax(umax(umax(T_WORD, T_BFIRST), umax(T_BNEXT, T_BEND)),
                                      umax(T_SEG, T_MASS));
  localparam int unsigned CW   = $clog2(TMAX + 1);
  localparam int unsigned IW   = $clog2(BLK_ITEMS + 1);

  logic          accept, reject;
  logic [CW-1:0] dur;
  pkind_e        kind;
  logic          open_q, open_d;
  logic [IW-1:0] items_q, items_d;
  logic          lock_q, lock_d;
  logic          viol_q, viol_d;
  logic          items_full, prog_start, erase_start;
  fop_e          op;

  assign op         = fop_e'(cmd_op);
  assign items_full = (items_q == IW'(BLK_ITEMS));

  flash_seq_gate i_gate (
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_prot  (cmd_prot),
    .busy      (busy),
    .blk_open  (open_q),
    .items_full(items_full),
    .locked    (lock_q),
    .accept    (accept),
    .reject    (reject)
  );

  always_comb begin
    case (op)
      OP_WORD:   begin dur = CW'(T_WORD);   kind = PK_PROG;  end
      OP_BSTART: begin dur = CW'(T_BFIRST); kind = PK_PROG;  end
      OP_BNEXT:  begin dur = CW'(T_BNEXT);  kind = PK_PROG;  end
      OP_BEND:   begin dur = CW'(T_BEND);   kind = PK_NONE;  end
      OP_SERASE: begin dur = CW'(T_SEG);    kind = PK_ERASE; end
      OP_MERASE: begin dur = CW'(T_MASS);   kind = PK_ERASE; end
      default:   begin dur = '0;            kind = PK_NONE;  end
    endcase
  end

  flash_seq_timer #(.CW(CW)) i_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .load_val   (dur),
    .load_kind  (kind),
    .busy       (busy),
    .prog_pulse (prog_pulse),
    .erase_pulse(erase_pulse)
  );

  assign prog_start  = accept && (op == OP_WORD || op == OP_BSTART);
  assign erase_start = accept && (op == OP_SERASE || op == OP_MERASE);

  flash_seq_cum #(.LIMIT(CUM_LIMIT), .BLK_AW(BLK_AW)) i_cum (
    .clk        (clk),
    .rst_n      (rst_n),
    .prog_start (prog_start),
    .erase_start(erase_start),
    .blk        (cmd_blk),
    .prog_pulse (prog_pulse),
    .err        (cum_err)
  );

  always_comb begin
    open_d  = open_q;
    items_d = items_q;
    if (accept && op == OP_BSTART) begin
      open_d  = 1'b1;
      items_d = IW'(1);
    end else if (accept && op == OP_BNEXT) begin
      items_d = items_q + 1'b1;
    end else if (accept && op == OP_BEND) begin
      open_d  = 1'b0;
      items_d = '0;
    end
    lock_d = prot_lock ? 1'b1 : (prot_unlock ? 1'b0 : lock_q);
    viol_d = viol_q || reject;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      items_q <= '0;
      lock_q  <= 1'b1;
      viol_q  <= 1'b0;
    end else begin
      open_q  <= open_d;
      items_q <= items_d;
      lock_q  <= lock_d;
      viol_q  <= viol_d;
    end
  end

  assign blk_open    = open_q;
  assign prot_locked = lock_q;
  assign acc_viol    = viol_q;

  p_viol_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_viol |=> acc_viol);
  p_blk_items_r3: assert property (@(posedge clk) disable iff (!rst_n)
    items_q <= IW'(BLK_ITEMS));
  p_end_no_prog_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_BEND) |=> (busy && !prog_pulse));

endmodule

// File: tb/test_flash_seq_top.sv
module test_flash_seq_top;

  logic       clk;
  logic       rst_n;
  logic       cmd_valid;
  logic [2:0] cmd_op;
  logic       cmd_prot;
  logic [3:0] cmd_blk;
  logic       prot_unlock, prot_lock;
  logic       busy, prog_pulse, erase_pulse, blk_open, prot_locked, acc_viol, cum_err;

  int checks = 0;
  int errors = 0;

  flash_seq_top i_flash_seq_top (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_prot(cmd_prot), .cmd_blk(cmd_blk), .prot_unlock(prot_unlock),
    .prot_lock(prot_lock), .busy(busy), .prog_pulse(prog_pulse),
    .erase_pulse(erase_pulse), .blk_open(blk_open), .prot_locked(prot_locked),
    .acc_viol(acc_viol), .cum_err(cum_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    cmd_valid = 0; cmd_op = 0; cmd_prot = 0; cmd_blk = 0;
    prot_unlock = 0; prot_lock = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic run_op(input logic [2:0] op, input logic prot, input logic [3:0] blk,
                        output int nb, output int np, output int ne);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_prot = prot; cmd_blk = blk;
    @(negedge clk);
    cmd_valid = 0;
    nb = 0; np = 0; ne = 0;
    while (busy) begin
      nb++;
      if (prog_pulse) np++;
      if (erase_pulse) ne++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 busy", busy, 0);
    chk("R1 prog", prog_pulse, 0);
    chk("R1 erase", erase_pulse, 0);
    chk("R1 blk_open", blk_open, 0);
    chk("R1 locked", prot_locked, 1);
    chk("R1 viol", acc_viol, 0);
    chk("R1 cum_err", cum_err, 0);
  endtask

  task automatic t_word();
    int nb, np, ne;
    do_reset();
    run_op(3'd0, 0, 4'd1, nb, np, ne);
    chk("R2 word busy", nb, 30);
    chk("R2 word prog", np, 30);
    chk("R2 word erase", ne, 0);
    chk("R2 busy low after", busy, 0);
    chk("R2 no viol", acc_viol, 0);
  endtask

  task automatic t_block();
    int nb, np, ne;
    do_reset();
    run_op(3'd1, 0, 4'd2, nb, np, ne);
    chk("R3 first item", np, 25);
    chk("R3 blk_open", blk_open, 1);
    for (int i = 0; i < 63; i++) begin
      run_op(3'd2, 0, 4'd2, nb, np, ne);
      if (i == 0 || i == 62) chk("R3 next item", np, 18);
    end
    chk("R3 no viol within 64", acc_viol, 0);
    run_op(3'd2, 0, 4'd2, nb, np, ne);
    chk("R3 65th item refused", nb, 0);
    chk("R3 65th item viol", acc_viol, 1);
    run_op(3'd3, 0, 4'd2, nb, np, ne);
    chk("R4 end busy", nb, 6);
    chk("R4 end no prog", np, 0);
    chk("R4 blk closed", blk_open, 0);
  endtask

  task automatic t_erase();
    int nb, np, ne;
    do_reset();
    run_op(3'd4, 0, 4'd0, nb, np, ne);
    chk("R5 seg busy", nb, 4819);
    chk("R5 seg erase", ne, 4819);
    chk("R6 seg no prog", np, 0);
    run_op(3'd5, 0, 4'd0, nb, np, ne);
    chk("R6 mass busy", nb, 10593);
    chk("R6 mass erase", ne, 10593);
    chk("R6 mass no prog", np, 0);
  endtask

  task automatic t_busy_reject();
    int nb, np, ne;
    do_reset();
    @(negedge clk);
    cmd_valid = 1; cmd_op = 3'd4; cmd_prot = 0;
    @(negedge clk);
    cmd_valid = 0;
    nb = 0; np = 0; ne = 0;
    while (busy) begin
      nb++;
      if (prog_pulse) np++;
      if (erase_pulse) ne++;
      if (nb == 5) begin cmd_valid = 1; cmd_op = 3'd0; end
      else cmd_valid = 0;
      @(negedge clk);
    end
    chk("R7 erase unaffected", ne, 4819);
    chk("R7 no prog from refused", np, 0);
    chk("R7 viol set", acc_viol, 1);
    repeat (5) @(negedge clk);
    chk("R7 viol sticky", acc_viol, 1);
  endtask

  task automatic t_state_reject();
    int nb, np, ne;
    do_reset();
    run_op(3'd2, 0, 4'd0, nb, np, ne);
    chk("R8 next outside block", nb, 0);
    chk("R8 viol", acc_viol, 1);
    do_reset();
    run_op(3'd3, 0, 4'd0, nb, np, ne);
    chk("R8 end outside block", nb, 0);
    do_reset();
    run_op(3'd6, 0, 4'd0, nb, np, ne);
    chk("R8 code 6 refused", nb, 0);
    chk("R8 code 6 viol", acc_viol, 1);
    do_reset();
    run_op(3'd1, 0, 4'd0, nb, np, ne);
    run_op(3'd0, 0, 4'd0, nb, np, ne);
    chk("R8 word inside block", nb, 0);
    run_op(3'd4, 0, 4'd0, nb, np, ne);
    chk("R8 erase inside block", nb, 0);
    chk("R8 viol in block", acc_viol, 1);
    chk("R8 block still open", blk_open, 1);
  endtask

  task automatic t_lock();
    int nb, np, ne;
    do_reset();
    run_op(3'd0, 1, 4'd0, nb, np, ne);
    chk("R9 locked refuse", nb, 0);
    chk("R9 locked viol", acc_viol, 1);
    do_reset();
    @(negedge clk); prot_unlock = 1;
    @(negedge clk); prot_unlock = 0;
    chk("R9 unlocked", prot_locked, 0);
    run_op(3'd0, 1, 4'd0, nb, np, ne);
    chk("R9 unlocked write", np, 30);
    chk("R9 no viol", acc_viol, 0);
    @(negedge clk); prot_lock = 1; prot_unlock = 1;
    @(negedge clk); prot_lock = 0; prot_unlock = 0;
    chk("R9 relocked", prot_locked, 1);
  endtask

  task automatic t_cum();
    int nb, np, ne;
    do_reset();
    for (int i = 0; i < 158; i++) run_op(3'd0, 0, 4'd3, nb, np, ne);
    @(negedge clk);
    chk("R10 at 4740 no err", cum_err, 0);
    run_op(3'd0, 0, 4'd5, nb, np, ne);
    for (int i = 0; i < 158; i++) run_op(3'd0, 0, 4'd3, nb, np, ne);
    @(negedge clk);
    chk("R10 restart on new block", cum_err, 0);
    run_op(3'd0, 0, 4'd3, nb, np, ne);
    @(negedge clk);
    chk("R10 over limit err", cum_err, 1);
    run_op(3'd4, 0, 4'd3, nb, np, ne);
    chk("R10 err sticky", cum_err, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_word();
    t_block();
    t_erase();
    t_busy_reject();
    t_state_reject();
    t_lock();
    t_cum();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule